// File: doc/BRIEF.md
# I2S Audio Transmitter with Transmit FIFO

This block turns 32-bit stereo frames into a serial I2S bit stream. Software or a DMA engine writes frames into a 16-word transmit FIFO. Each word carries the left sample in its upper half and the right sample in its lower half. The serializer pops one word per LRCK period and shifts both 16-bit samples out MSB first, in the standard I2S position. The FIFO raises a DMA request whenever it holds half its depth or less, so a DMA engine can keep it topped up.

In master mode the block divides the system clock into MCLK (clk/2), SCLK (MCLK/4) and LRCK (SCLK/64), so MCLK is 256 times the sample rate. Bit clocks start only when the start control is set. In slave mode the block takes SCLK and LRCK from outside through two-flop synchronisers, and it realigns its slot counter to every LRCK edge. The start control has no effect in that mode.

Top module: `i2s_tx`

## Requirements
- R1: In master mode with transmit running, mclk_o has a period of 2 clk_i cycles, sclk_o has a period of 8 clk_i cycles, and lrck_o has a period of 64 sclk_o cycles (512 clk_i).
- R2: In master mode with tx_start_i low, mclk_o and sclk_o stay low and no serial data advances. After reset, lrck_o idles high.
- R3: A frame starts when lrck_o falls. With slot 0 at that falling edge, wr_data_i[31:16] goes out MSB first in slots 1 to 16 while LRCK is low, and wr_data_i[15:0] goes out MSB first in slots 33 to 48 while LRCK is high. All other slots carry 0. sdata_o changes only on SCLK falling edges.
- R4: The FIFO holds up to 16 words, which are sent in write order. A write while the FIFO is full is dropped.
- R5: dma_req_o is high exactly when the FIFO holds 8 or fewer words.
- R6: A one-cycle pulse on fifo_rst_i empties the FIFO and clears underrun_o.
- R7: If the FIFO is empty when a frame starts, that frame carries all zeros and underrun_o is set. underrun_o stays set until fifo_rst_i is pulsed.
- R8: In slave mode, sclk_i and lrck_i are synchronised to clk_i. sdata_o changes after each falling edge of sclk_i, and a frame starts at each falling edge of lrck_i. tx_start_i is ignored, and mclk_o, sclk_o and lrck_o are held low.
- R9: After reset, the FIFO is empty, dma_req_o is 1, underrun_o is 0 and sdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = clock master, 0 = slave |
| tx_start_i | input | 1 | Runs the bit clocks in master mode |
| fifo_rst_i | input | 1 | Flushes the FIFO and clears underrun |
| wr_valid_i | input | 1 | FIFO write strobe |
| wr_data_i | input | 32 | Stereo frame: left in [31:16], right in [15:0] |
| sclk_i | input | 1 | External bit clock (slave mode) |
| lrck_i | input | 1 | External word clock (slave mode) |
| mclk_o | output | 1 | Master clock out (master mode) |
| sclk_o | output | 1 | Bit clock out (master mode) |
| lrck_o | output | 1 | Word clock out (master mode) |
| sdata_o | output | 1 | Serial audio data |
| dma_req_o | output | 1 | FIFO at or below half full |
| underrun_o | output | 1 | Sticky empty-at-frame-start flag |

## Verification
Some properties are checked on every cycle:
- The FIFO never exceeds its depth, drops writes while full, and empties on a flush.
- The serializer never pops an empty FIFO.
- The underrun flag, once set, stays set until a flush.
- sdata_o moves only on a bit-clock tick.
- In master mode the slot counter steps by one per tick, and no tick occurs while start is low.
- In slave mode the slot counter realigns on each LRCK edge.

Other behaviour can only be shown by the bench scenarios:
- The exact bit positions of both samples inside a frame.
- The write order across a full FIFO, and the dropping of excess writes.
- The clock periods.
- The DMA threshold at 8 and 9 words.
- The zero frame and flag after an underrun.
- Framing against an external clock pair.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int FRAME_W    = 2 * SAMPLE_W;
  localparam int HALF_SLOTS = 32;
  localparam int SLOT_W     = $clog2(2 * HALF_SLOTS);
  localparam int POS_W      = SLOT_W - 1;
  localparam int BIT_IDX_W  = $clog2(SAMPLE_W);
  // clk/2 = MCLK, MCLK/4 = SCLK -> 3-bit prescaler
  localparam int PRE_W      = 3;
  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [SLOT_W-1:0]  slot_t;
endpackage

// File: rtl/i2s_tx_fifo.sv
`timescale 1ns/1ps
module i2s_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             full, do_wr, do_rd;

  assign full  = (cnt_q == CW'(DEPTH));
  assign do_wr = wr_i && !full;
  assign do_rd = rd_i && (cnt_q != '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= nxt(wp_q);
      if (do_rd) rp_q <= nxt(rp_q);
      if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  // R4
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R4
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && wr_i && !rd_i && !flush_i) |=> (cnt_q == CW'(DEPTH)));
  // R6
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  // R7
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
endmodule

// File: rtl/i2s_tx_clkgen.sv
`timescale 1ns/1ps
module i2s_tx_clkgen
  import i2s_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic start_i,
  input  logic sclk_i,
  input  logic lrck_i,
  output logic tick_o,
  output logic lr_o,
  output logic mclk_o,
  output logic sclk_o
);
  logic [PRE_W-1:0] pre_q;
  logic [1:0]       sclk_sync_q, lrck_sync_q;
  logic             sclk_prev_q;
  logic             run, tick_m, tick_s;

  assign run = master_i && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (!run) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sync_q <= '0;
      lrck_sync_q <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_sync_q <= {sclk_sync_q[0], sclk_i};
      lrck_sync_q <= {lrck_sync_q[0], lrck_i};
      sclk_prev_q <= sclk_sync_q[1];
    end
  end

  // SCLK falls as the prescaler wraps
  assign tick_m = run && (pre_q == '1);
  assign tick_s = sclk_prev_q && !sclk_sync_q[1];
  assign tick_o = master_i ? tick_m : tick_s;
  assign lr_o   = lrck_sync_q[1];
  assign mclk_o = master_i && pre_q[0];
  assign sclk_o = master_i && pre_q[PRE_W-1];

  // R2
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !start_i) |-> !tick_o);
  // R1
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && master_i) |=> (!tick_o || !master_i));
endmodule

// File: rtl/i2s_tx_ser.sv
`timescale 1ns/1ps
module i2s_tx_ser
  import i2s_tx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   master_i,
  input  logic   tick_i,
  input  logic   lr_i,
  input  logic   flush_i,
  input  logic   fifo_empty_i,
  input  frame_t fifo_data_i,
  output logic   pop_o,
  output logic   sdata_o,
  output logic   lrck_o,
  output logic   underrun_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SAMPLE_W);

  slot_t  slot_q, slot_nxt;
  logic   lr_prev_q, frame_start, active, urun_q;
  frame_t frame_q;
  logic [POS_W-1:0]     pos;
  logic [POS_W-1:0]     idx_full;
  logic [SAMPLE_W-1:0]  sample;

  always_comb begin
    slot_nxt = slot_q + 1'b1;
    if (!master_i && (lr_i != lr_prev_q)) slot_nxt = {lr_i, {POS_W{1'b0}}};
  end

  assign frame_start = tick_i && (slot_nxt == '0);
  assign pop_o       = frame_start && !fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= '1;
      lr_prev_q <= 1'b1;
      frame_q   <= '0;
    end else if (tick_i) begin
      slot_q    <= slot_nxt;
      lr_prev_q <= lr_i;
      if (frame_start) frame_q <= fifo_empty_i ? '0 : fifo_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         urun_q <= 1'b0;
    else if (flush_i)                    urun_q <= 1'b0;
    else if (frame_start && fifo_empty_i) urun_q <= 1'b1;
  end

  // slot 0 is the delay slot after the LRCK edge
  assign pos      = slot_q[POS_W-1:0];
  assign active   = (pos != '0) && (pos <= LAST_POS);
  assign sample   = slot_q[SLOT_W-1] ? frame_q[SAMPLE_W-1:0] : frame_q[FRAME_W-1:SAMPLE_W];
  assign idx_full = LAST_POS - pos;
  assign sdata_o  = active && sample[idx_full[BIT_IDX_W-1:0]];
  assign lrck_o   = master_i && slot_q[SLOT_W-1];
  assign underrun_o = urun_q;

  // R7
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !flush_i) |=> underrun_o);
  // R3
  sdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sdata_o));
  // R1
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && master_i) |=> (slot_q == SLOT_W'($past(slot_q) + 1'b1)));
  // R8
  slave_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !master_i && (lr_i != lr_prev_q)) |=> (slot_q[POS_W-1:0] == '0));
endmodule

// File: rtl/i2s_tx.sv
`timescale 1ns/1ps
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TRIG_LEVEL = FIFO_DEPTH / 2,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               master_i,
  input  logic               tx_start_i,
  input  logic               fifo_rst_i,
  input  logic               wr_valid_i,
  input  logic [FRAME_W-1:0] wr_data_i,
  input  logic               sclk_i,
  input  logic               lrck_i,
  output logic               mclk_o,
  output logic               sclk_o,
  output logic               lrck_o,
  output logic               sdata_o,
  output logic               dma_req_o,
  output logic               underrun_o
);
  logic    tick, lr, pop, empty;
  frame_t  rdata;
  logic [CW-1:0] count;

  i2s_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FRAME_W)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (fifo_rst_i),
    .wr_i    (wr_valid_i),
    .wdata_i (wr_data_i),
    .rd_i    (pop),
    .rdata_o (rdata),
    .empty_o (empty),
    .count_o (count)
  );

  i2s_tx_clkgen u_clk (
    .clk_i, .rst_ni, .master_i,
    .start_i (tx_start_i),
    .sclk_i, .lrck_i,
    .tick_o  (tick),
    .lr_o    (lr),
    .mclk_o, .sclk_o
  );

  i2s_tx_ser u_ser (
    .clk_i, .rst_ni, .master_i,
    .tick_i       (tick),
    .lr_i         (lr),
    .flush_i      (fifo_rst_i),
    .fifo_empty_i (empty),
    .fifo_data_i  (rdata),
    .pop_o        (pop),
    .sdata_o, .lrck_o, .underrun_o
  );

  assign dma_req_o = (count <= CW'(TRIG_LEVEL));
endmodule

// File: tb/i2s_tx_tb.sv
`timescale 1ns/1ps
module i2s_tx_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic master_i = 1'b1, tx_start_i = 1'b0, fifo_rst_i = 1'b0;
  logic wr_valid_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic ext_sclk = 1'b0, ext_lrck = 1'b1, slv_en = 1'b0;
  logic [5:0] ext_slot = 6'd63;
  logic mclk_o, sclk_o, lrck_o, sdata_o, dma_req_o, underrun_o;
  logic slave_phase = 1'b0, bad_clk = 1'b0;
  int checks = 0, errors = 0;

  localparam logic [31:0] VEC [16] = '{
    32'h8001_7FFE, 32'hFFFF_0000, 32'h0000_FFFF, 32'hA5A5_5A5A,
    32'h1234_5678, 32'h8000_0001, 32'h0001_8000, 32'hDEAD_BEEF,
    32'hC3C3_3C3C, 32'h0F0F_F0F0, 32'h7FFF_8000, 32'h5555_AAAA,
    32'h0102_0304, 32'hFEDC_BA98, 32'h4000_0002, 32'h9999_6666};

  always #5 clk = ~clk;

  i2s_tx u_dut (
    .clk_i(clk), .rst_ni, .master_i, .tx_start_i, .fifo_rst_i,
    .wr_valid_i, .wr_data_i, .sclk_i(ext_sclk), .lrck_i(ext_lrck),
    .mclk_o, .sclk_o, .lrck_o, .sdata_o, .dma_req_o, .underrun_o);

  // external clock pair for slave mode: LRCK moves on SCLK falling edges
  always begin
    #80;
    if (slv_en) ext_sclk = ~ext_sclk;
  end
  always @(negedge ext_sclk) begin
    ext_slot = ext_slot + 1'b1;
    ext_lrck = ext_slot[5];
  end
  always @(posedge clk)
    if (slave_phase && (mclk_o || sclk_o || lrck_o)) bad_clk <= 1'b1;

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    return {1'b0, w[31:16], 15'b0, 1'b0, w[15:0], 15'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_valid_i = 1'b1;
    wr_data_i  = w;
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic cap_master(output logic [63:0] f);
    f = '0;
    @(negedge lrck_o);
    repeat (64) begin
      @(posedge sclk_o);
      #1 f = {f[62:0], sdata_o};
    end
  endtask

  task automatic cap_slave(output logic [63:0] f);
    f = '0;
    @(negedge ext_lrck);
    repeat (64) begin
      @(posedge ext_sclk);
      #1 f = {f[62:0], sdata_o};
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] f;
    realtime t0, t1;
    bit moved;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(dma_req_o == 1'b1, "R9 dma_req", 64'(dma_req_o), 64'd1);
    chk(underrun_o == 1'b0, "R9 underrun", 64'(underrun_o), 64'd0);
    chk(sdata_o == 1'b0, "R9 sdata", 64'(sdata_o), 64'd0);
    chk(lrck_o == 1'b1, "R2 idle lrck", 64'(lrck_o), 64'd1);

    // R5 threshold while the link is stopped, R4 overfill
    for (int i = 0; i < 8; i++) wr(VEC[i]);
    @(negedge clk);
    chk(dma_req_o == 1'b1, "R5 at 8 words", 64'(dma_req_o), 64'd1);
    wr(VEC[8]);
    @(negedge clk);
    chk(dma_req_o == 1'b0, "R5 at 9 words", 64'(dma_req_o), 64'd0);
    for (int i = 9; i < 16; i++) wr(VEC[i]);
    for (int i = 0; i < 4; i++) wr(32'hFFFF_FFFF);  // dropped when full

    // R2 no clocks while start is low
    moved = 1'b0;
    repeat (200) begin
      @(negedge clk);
      if (mclk_o || sclk_o) moved = 1'b1;
    end
    chk(!moved, "R2 clocks idle", 64'(moved), 64'd0);

    // R3 / R4 table walk: frames follow write order
    @(negedge clk);
    tx_start_i = 1'b1;
    for (int i = 0; i < 16; i++) begin
      cap_master(f);
      chk(f == exp_frame(VEC[i]), $sformatf("R3 R4 frame %0d", i), f, exp_frame(VEC[i]));
      if (i == 0) chk(underrun_o == 1'b0, "R7 no early underrun", 64'(underrun_o), 64'd0);
    end
    // R7 empty at frame start -> zero frame, flag set
    cap_master(f);
    chk(f == '0, "R7 zero frame", f, '0);
    chk(underrun_o == 1'b1, "R7 underrun set", 64'(underrun_o), 64'd1);

    // R1 clock periods
    @(posedge mclk_o); t0 = $realtime;
    @(posedge mclk_o); t1 = $realtime;
    chk(t1 - t0 == 20.0, "R1 mclk period", 64'(int'(t1 - t0)), 64'd20);
    @(posedge sclk_o); t0 = $realtime;
    @(posedge sclk_o); t1 = $realtime;
    chk(t1 - t0 == 80.0, "R1 sclk period", 64'(int'(t1 - t0)), 64'd80);
    @(negedge lrck_o); t0 = $realtime;
    @(negedge lrck_o); t1 = $realtime;
    chk(t1 - t0 == 5120.0, "R1 lrck period", 64'(int'(t1 - t0)), 64'd5120);

    // R6 flush
    @(negedge clk);
    tx_start_i = 1'b0;
    for (int i = 0; i < 12; i++) wr(32'h1111_1111 * (i + 1));
    @(negedge clk);
    chk(dma_req_o == 1'b0, "R5 at 12 words", 64'(dma_req_o), 64'd0);
    chk(underrun_o == 1'b1, "R7 still set", 64'(underrun_o), 64'd1);
    fifo_rst_i = 1'b1;
    @(negedge clk);
    fifo_rst_i = 1'b0;
    @(negedge clk);
    chk(dma_req_o == 1'b1, "R6 flush empties", 64'(dma_req_o), 64'd1);
    chk(underrun_o == 1'b0, "R6 flush clears underrun", 64'(underrun_o), 64'd0);
    wr(32'h6C6C_9393);
    tx_start_i = 1'b1;
    cap_master(f);
    chk(f == exp_frame(32'h6C6C_9393), "R6 only new word sent", f, exp_frame(32'h6C6C_9393));
    @(negedge clk);
    tx_start_i = 1'b0;

    // R8 slave mode, start ignored
    master_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    slave_phase = 1'b1;
    wr(VEC[7]);
    wr(VEC[13]);
    slv_en = 1'b1;
    cap_slave(f);
    chk(f == exp_frame(VEC[7]), "R8 slave frame 0", f, exp_frame(VEC[7]));
    cap_slave(f);
    chk(f == exp_frame(VEC[13]), "R8 slave frame 1", f, exp_frame(VEC[13]));
    cap_slave(f);
    chk(f == '0, "R7 slave underrun frame", f, '0);
    chk(underrun_o == 1'b1, "R7 slave underrun flag", 64'(underrun_o), 64'd1);
    chk(!bad_clk, "R8 master clocks held low", 64'(bad_clk), 64'd0);

    summary();
  end
endmodule